// File: doc/BRIEF.md
# Phase-Continuous Two-Tone FSK Modulator

This block turns a serial bit stream, as a host UART shifts it out, into a digitally synthesized sine wave. The wave's frequency follows the current bit level. A numerically controlled oscillator adds one of two phase increments to a phase accumulator on every master clock. The top bits of the accumulator address a quarter-wave sine table. The table's result is registered as a signed sample word for an external DAC.

When the bit level changes, only the increment is switched. The accumulator keeps its phase, so the output never jumps at a bit boundary. A transmit-request input gates the oscillator. While the request is low, the accumulator is held cleared and the sample word rests at mid-scale (zero). Both inputs pass through a synchronizer before use, because the host drives them without regard to this clock.

Top module: `fsk_tone_synth`

## Requirements
- R1: With `tx_bit` = 1 and `tx_req` = 1, the output is the mark tone. Its per-clock phase step is round(1200·2^24/CLK_HZ), which is 1200 Hz at 3.6864 MHz, or about 3072 clocks per cycle.
- R2: With `tx_bit` = 0 and `tx_req` = 1, the output is the space tone. Its per-clock phase step is round(2200·2^24/CLK_HZ), which is 2200 Hz at 3.6864 MHz, or about 1676 clocks per cycle.
- R3: While transmitting, two consecutive samples never differ by more than 16 LSB. This holds when `tx_bit` changes at any rate, because the accumulator is never reloaded and only the step between the two tone values is switched.
- R4: While `tx_req` is low, `sample_out` is 0. It reaches 0 within 4 clocks after `tx_req` falls and holds there whatever `tx_bit` does.
- R5: Each transmit burst starts from phase zero. The first nonzero sample after `tx_req` rises is positive and no larger than 16.
- R6: The reset `rst_n` is synchronous and active low. It clears all state, so `sample_out` is 0 one clock after it is sampled low.
- R7: The sine is full scale and symmetric. Over a full cycle the largest sample is +(2^(OUT_W-1)-1) and the smallest is -(2^(OUT_W-1)-1), which is ±511 for 10-bit output. The code -2^(OUT_W-1) never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, nominally CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_req | input | 1 | Transmit request; high enables the oscillator |
| tx_bit | input | 1 | Serial data bit from the host UART (1 = mark, 0 = space) |
| sample_out | output | OUT_W | Signed two's-complement sine sample for the DAC |

## Verification
The bench holds the bit steady at 1 and then at 0, and counts rising zero crossings over fixed windows. This separates the two tone steps and would expose swapped or mis-scaled increments. It then toggles the bit once per bit period and, separately, every few dozen clocks, while it tracks the largest sample-to-sample step. An accumulator reload or any phase jump shows up only under those switching patterns. Idle stretches with a toggling bit, a re-enable and a mid-burst reset show apart the gating, the restart-at-zero phase and the reset paths.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  // Phase step per clock for a tone: round(tone * 2^acc_w / clk)
  function automatic longint tone_step(longint tone_hz, longint clk_hz, int acc_w);
    longint scaled;
    scaled = tone_hz <<< acc_w;
    return (scaled + clk_hz / 2) / clk_hz;
  endfunction

  // Quarter-wave magnitude at table point u of qn points per quarter.
  // Rational sine approximation over the half wave, scaled to amp.
  function automatic int quarter_sine(int u, int qn, int amp);
    longint h;
    longint p;
    longint num;
    longint den;
    h   = 2 * longint'(qn);
    p   = longint'(u) * (h - longint'(u));
    num = 4 * p * longint'(amp);
    den = (5 * h * h) / 4 - p;
    return int'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/fsk_in_sync.sv
module fsk_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int               ACC_W     = 24,
  parameter logic [ACC_W-1:0] MARK_INC  = '0,
  parameter logic [ACC_W-1:0] SPACE_INC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tone_bit,
  output logic [ACC_W-1:0] step_sel,
  output logic [ACC_W-1:0] phase_q,
  output logic             run_q
);

  // Only the step is switched; the accumulator carries its phase across bits.
  assign step_sel = tone_bit ? MARK_INC : SPACE_INC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else if (!enable) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_q + step_sel;
      run_q   <= 1'b1;
    end
  end

endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [ACC_W-1:0]        phase,
  output logic signed [OUT_W-1:0] sample
);
  import fsk_pkg::*;

  localparam int QN  = 1 << (ADDR_W - 2);
  localparam int AMP = (1 << (OUT_W - 1)) - 1;

  logic [OUT_W-2:0] qtab [QN+1];

  genvar g;
  generate
    for (g = 0; g <= QN; g++) begin : g_tab
      assign qtab[g] = (OUT_W-1)'(quarter_sine(g, QN, AMP));
    end
  endgenerate

  logic [ADDR_W-1:0]        addr;
  logic [1:0]               quad;
  logic [ADDR_W-3:0]        off;
  logic [ADDR_W-2:0]        idx;
  logic [OUT_W-2:0]         mag;
  logic signed [OUT_W-1:0]  sval;

  assign addr = phase[ACC_W-1 -: ADDR_W];
  assign quad = addr[ADDR_W-1 -: 2];
  assign off  = addr[ADDR_W-3:0];

  always_comb begin
    // Odd quadrants run the quarter table backwards, upper half is negated.
    if (quad[0]) idx = (ADDR_W-1)'(QN) - {1'b0, off};
    else         idx = {1'b0, off};
    mag  = qtab[idx];
    sval = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sample <= '0;
    else if (!run) sample <= '0;
    else           sample <= sval;
  end

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth #(
  parameter longint CLK_HZ      = 3686400,
  parameter longint MARK_HZ     = 1200,
  parameter longint SPACE_HZ    = 2200,
  parameter int     ACC_W       = 24,
  parameter int     ADDR_W      = 8,
  parameter int     OUT_W       = 10,
  parameter int     SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_req,
  input  logic                    tx_bit,
  output logic signed [OUT_W-1:0] sample_out
);
  import fsk_pkg::*;

  localparam logic [ACC_W-1:0] MARK_INC  = ACC_W'(tone_step(MARK_HZ, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] SPACE_INC = ACC_W'(tone_step(SPACE_HZ, CLK_HZ, ACC_W));

  // Named internal events, brought out for the checker
  logic             tx_en_s;
  logic             tone_bit_s;
  logic [ACC_W-1:0] step_sel;
  logic [ACC_W-1:0] phase_q;
  logic             run_q;

  fsk_in_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({tx_req, tx_bit}),
    .q     ({tx_en_s, tone_bit_s})
  );

  fsk_phase_acc #(.ACC_W(ACC_W), .MARK_INC(MARK_INC), .SPACE_INC(SPACE_INC)) u_nco (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_en_s),
    .tone_bit (tone_bit_s),
    .step_sel (step_sel),
    .phase_q  (phase_q),
    .run_q    (run_q)
  );

  fsk_sine_lut #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .phase  (phase_q),
    .sample (sample_out)
  );

endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk #(
  parameter int               ACC_W     = 24,
  parameter int               OUT_W     = 10,
  parameter logic [ACC_W-1:0] MARK_INC  = '0,
  parameter logic [ACC_W-1:0] SPACE_INC = '0,
  parameter int               MAX_STEP  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_q,
  input logic [ACC_W-1:0]        phase_q,
  input logic signed [OUT_W-1:0] sample_out
);

  logic signed [OUT_W:0] prev_s;
  logic signed [OUT_W:0] diff_s;
  logic [ACC_W-1:0]      phase_prev;

  always_ff @(posedge clk) begin
    prev_s     <= {sample_out[OUT_W-1], sample_out};
    phase_prev <= phase_q;
  end
  assign diff_s = {sample_out[OUT_W-1], sample_out} - prev_s;

  // R3: the accumulator only ever advances by one of the two tone steps
  p_inc_choice_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |->
      ((phase_q - phase_prev) == MARK_INC || (phase_q - phase_prev) == SPACE_INC));

  // R3: no step between consecutive samples while transmitting
  p_slope_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && $past(run_q, 2)) |->
      (diff_s <= MAX_STEP && diff_s >= -MAX_STEP));

  // R4: idle oscillator gives mid-scale
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (sample_out == '0));

  // R5: a burst starts from a cleared accumulator
  p_start_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (phase_q == MARK_INC || phase_q == SPACE_INC));

  // R7: the most negative code is never produced
  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_out != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .MARK_INC(MARK_INC), .SPACE_INC(SPACE_INC), .MAX_STEP(16)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .phase_q    (phase_q),
  .sample_out (sample_out)
);

// File: tb/fsk_tone_synth_test.sv
module fsk_tone_synth_test;

  localparam int    OUT_W = 10;
  localparam int    SKIP  = 8;
  localparam int    MAXST = 16;
  localparam int    PEAK  = (1 << (OUT_W - 1)) - 1;
  localparam longint CLKF = 3686400;

  typedef enum int {K_RISE, K_MAXSTEP, K_MAXABS, K_PEAK, K_TROUGH, K_FIRSTNZ} kind_t;
  typedef struct {
    kind_t kind;
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic tx_bit = 1'b0;
  logic signed [OUT_W-1:0] sample_out;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic seg_start = 1'b0;
  logic seg_end = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  fsk_tone_synth uut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_bit(tx_bit), .sample_out(sample_out)
  );

  // Tone step restated from the rate: nearest integer of f * 2^24 / clk
  function automatic longint step_of(longint f);
    longint num;
    num = f * 64'd33554432;
    return (num + CLKF) / (2 * CLKF);
  endfunction

  function automatic int rises_in(int n, longint step);
    return int'((longint'(n) * step) >>> 24);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_item(kind_t k, int lo, int hi, string tag);
    exp_t e;
    e.kind = k; e.lo = lo; e.hi = hi; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run_seg(bit req, bit b, int toggle, int clocks);
    tx_req = req; tx_bit = b; seg_start = 1'b1;
    @(posedge clk); #1 seg_start = 1'b0;
    for (int n = 1; n < clocks; n++) begin
      if (toggle > 0 && (n % toggle) == 0) tx_bit = ~tx_bit;
      @(posedge clk); #1;
    end
    seg_end = 1'b1;
    @(posedge clk); #1 seg_end = 1'b0;
  endtask

  // Monitor: gathers waveform metrics and pops the scoreboard at segment end
  int age, rises, maxstep, maxabs, peak, trough, firstnz;
  bit have_prev;
  int prev;
  always @(negedge clk) begin
    int cur;
    int mv;
    cur = int'(sample_out);
    if (seg_start) begin
      age = 0; rises = 0; maxstep = 0; maxabs = 0; peak = -9999; trough = 9999;
      firstnz = 0; have_prev = 1'b0;
    end else if (seg_end) begin
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        case (e.kind)
          K_RISE:    mv = rises;
          K_MAXSTEP: mv = maxstep;
          K_MAXABS:  mv = maxabs;
          K_PEAK:    mv = peak;
          K_TROUGH:  mv = trough;
          default:   mv = firstnz;
        endcase
        check(mv >= e.lo && mv <= e.hi, e.tag, mv, e.lo);
      end
    end else begin
      age++;
      if (age > SKIP) begin
        if (have_prev) begin
          if (prev < 0 && cur >= 0) rises++;
          if (cur - prev > maxstep) maxstep = cur - prev;
          if (prev - cur > maxstep) maxstep = prev - cur;
        end
        if (cur > maxabs) maxabs = cur;
        if (-cur > maxabs) maxabs = -cur;
        if (cur > peak) peak = cur;
        if (cur < trough) trough = cur;
        if (firstnz == 0 && cur != 0) firstnz = cur;
        prev = cur;
        have_prev = 1'b1;
      end
    end
  end

  initial begin
    longint mk;
    longint sp;
    int w;
    mk = step_of(1200);
    sp = step_of(2200);

    // R6: outputs held at zero in reset even with transmit requested
    tx_req = 1'b1; tx_bit = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); check(sample_out == 0, "R6 in reset", int'(sample_out), 0);
    #1 tx_req = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check(sample_out == 0, "R6 after reset", int'(sample_out), 0);
    @(posedge clk); #1;

    // R4: idle with a busy data line
    expect_item(K_MAXABS, 0, 0, "R4 idle toggling bit");
    run_seg(1'b0, 1'b1, 5, 2000);

    // R1, R5, R7: steady mark
    w = 30720 - SKIP - 1;
    expect_item(K_FIRSTNZ, 1, MAXST, "R5 first sample positive");
    expect_item(K_RISE, rises_in(w, mk) - 1, rises_in(w, mk) + 1, "R1 mark crossings");
    expect_item(K_PEAK, PEAK, PEAK, "R7 positive peak");
    expect_item(K_TROUGH, -PEAK, -PEAK, "R7 negative peak");
    expect_item(K_MAXSTEP, 0, MAXST, "R3 mark slope");
    run_seg(1'b1, 1'b1, 0, 30720);

    // R2: steady space
    w = 20000 - SKIP - 1;
    expect_item(K_RISE, rises_in(w, sp) - 1, rises_in(w, sp) + 1, "R2 space crossings");
    expect_item(K_MAXSTEP, 0, MAXST, "R3 space slope");
    expect_item(K_PEAK, PEAK, PEAK, "R7 space peak");
    run_seg(1'b1, 1'b0, 0, 20000);

    // R3: bit-rate alternation, crossings follow the mean of both steps
    w = 30720 - SKIP - 1;
    expect_item(K_MAXSTEP, 0, MAXST, "R3 bit-rate switching slope");
    expect_item(K_RISE, rises_in(w, (mk + sp) / 2) - 2, rises_in(w, (mk + sp) / 2) + 2,
                "R3 alternating crossings");
    run_seg(1'b1, 1'b1, 3072, 30720);

    // R3: fast switching
    expect_item(K_MAXSTEP, 0, MAXST, "R3 fast switching slope");
    run_seg(1'b1, 1'b0, 37, 5000);

    // R4: drop request mid-wave
    expect_item(K_MAXABS, 0, 0, "R4 idle after burst");
    run_seg(1'b0, 1'b0, 11, 2000);

    // R5: re-enable on space
    expect_item(K_FIRSTNZ, 1, MAXST, "R5 restart at zero phase");
    run_seg(1'b1, 1'b0, 0, 3000);

    // R6: reset in the middle of a burst
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); check(sample_out == 0, "R6 mid-burst reset", int'(sample_out), 0);
    @(posedge clk); #1 rst_n = 1'b1; tx_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); check(sample_out == 0, "R6 idle after reset", int'(sample_out), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule